// File: doc/BRIEF.md
# Burst column address sequencer

This block sits in the command path of a low-power DDR memory controller. It holds the mode settings for burst accesses and, for every READ or WRITE command, produces one column address per data beat. A mode-register-set strobe, qualified by a zero bank selector, loads the address-bus value. The block decodes the burst length, the beat ordering and the CAS latency from that value. Any reserved code, or a set bit above the defined fields, is refused and raises a sticky error flag.

When a command arrives, the starting column splits in two. The bits above log2(BL) choose an aligned block of BL columns. The low bits give the first position inside that block. The beats then walk the block in sequential order, (start + i) mod BL, or in interleaved order, start XOR i, and wrap within the block. A command that arrives while a burst is running cuts that burst short and starts the new one on the following cycle. Length and ordering are taken when the command is accepted, so a mode write made during a burst does not touch it.

Top module: `burst_col_seq`

## Requirements
- R1: After reset the sequencer reports a burst of 2 beats, sequential order, CAS latency 3, no error flag and no beat valid.
- R2: A strobe with bank selector 0, a valid length code (bits 2:0: 001=2, 010=4, 011=8, 100=16 beats), a valid latency code (bits 6:4: 010=2, 011=3), bit 3 as the order (0 sequential, 1 interleaved) and zero above bit 6 updates the reported settings on the next cycle.
- R3: A strobe with bank selector 0 carrying a reserved length code (000, 101, 110, 111) or a reserved latency code sets the error flag and leaves all reported settings unchanged.
- R4: A strobe with a nonzero bank selector changes neither the settings nor the error flag. A strobe with bank 0 and any set bit above bit 6 is refused as in R3.
- R5: The first beat appears one cycle after a command, and the beats follow on consecutive cycles, exactly BL of them. The valid strobe then drops.
- R6: In sequential order, beat i carries low log2(BL) bits equal to (start + i) mod BL, and the column bits above them stay equal to those of the command.
- R7: In interleaved order, beat i carries low log2(BL) bits equal to start XOR i, and the upper column bits stay fixed.
- R8: The last-beat flag is high on the final beat of each burst and on no other cycle.
- R9: A command during a running burst ends it. The first beat of the new burst appears on the next cycle.
- R10: A mode write made during a burst does not change the length or the order of that burst.
- R11: Once set, the error flag stays high, even across later valid mode writes, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mrs_valid | input | 1 | Mode register set strobe |
| mrs_bank | input | 2 | Bank selector; must be 0 for a mode write |
| mrs_addr | input | ADDR_W | Address-bus value carrying the mode fields |
| cmd_valid | input | 1 | READ or WRITE command strobe |
| cmd_col | input | COL_W | Starting column of the command |
| beat_valid | output | 1 | A column address is presented this cycle |
| beat_col | output | COL_W | Column address of the current beat |
| beat_last | output | 1 | Current beat is the final one of its burst |
| cfg_beats | output | 5 | Programmed burst length in beats |
| cfg_interleave | output | 1 | Programmed order: 1 interleaved, 0 sequential |
| cfg_cas_lat | output | 2 | Programmed CAS latency in cycles |
| mode_err | output | 1 | Sticky flag for a refused mode write |

## Verification
Mode settings and the error flag change one clock edge after a mode strobe, so the bench reads them at the falling edge after that edge. Beat i of a burst is presented in the (i+1)-th cycle after the command edge. The valid strobe is low in the cycle after beat BL-1. Every check is sampled on a falling edge, and inputs change only on falling edges, so each sample sees only the register updates from the rising edge before it. After a mid-burst command, the next sample must already show beat 0 of the new burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  // offset field wide enough for the longest burst (16 beats)
  localparam int OFS_W = 4;

  typedef struct packed {
    logic [2:0] bl;
    logic       ileave;
    logic [2:0] cl;
  } mode_t;

  localparam mode_t MODE_RESET = '{bl: 3'b001, ileave: 1'b0, cl: 3'b011};

  function automatic logic bl_code_ok(input logic [2:0] c);
    return (c == 3'b001) || (c == 3'b010) || (c == 3'b011) || (c == 3'b100);
  endfunction

  function automatic logic cl_code_ok(input logic [2:0] c);
    return (c == 3'b010) || (c == 3'b011);
  endfunction

  // number of beats for a legal length code
  function automatic logic [4:0] beats_of(input logic [2:0] c);
    return 5'd1 << c;
  endfunction

  function automatic logic [OFS_W-1:0] ofs_mask(input logic [2:0] c);
    logic [4:0] b;
    b = beats_of(c) - 5'd1;
    return b[OFS_W-1:0];
  endfunction

  // position inside the aligned block for beat idx
  function automatic logic [OFS_W-1:0] beat_offset(input logic [OFS_W-1:0] start,
                                                   input logic [OFS_W-1:0] idx,
                                                   input logic [OFS_W-1:0] mask,
                                                   input logic             ileave);
    logic [OFS_W-1:0] raw;
    raw = ileave ? (start ^ idx) : (start + idx);
    return raw & mask;
  endfunction

endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrs_valid,
  input  logic [1:0]        mrs_bank,
  input  logic [ADDR_W-1:0] mrs_addr,
  output mode_t             mode,
  output logic              mode_err
);

  localparam int FIELD_W = 7;

  logic  upper_zero;
  logic  mrs_target;
  logic  fields_ok;
  logic  mrs_accept;
  logic  mrs_reject;
  mode_t req_mode;

  generate
    if (ADDR_W > FIELD_W) begin : g_upper
      assign upper_zero = ~|mrs_addr[ADDR_W-1:FIELD_W];
    end else begin : g_no_upper
      assign upper_zero = 1'b1;
    end
  endgenerate

  assign req_mode.bl     = mrs_addr[2:0];
  assign req_mode.ileave = mrs_addr[3];
  assign req_mode.cl     = mrs_addr[6:4];

  assign mrs_target = mrs_valid && (mrs_bank == 2'b00);
  assign fields_ok  = bl_code_ok(req_mode.bl) && cl_code_ok(req_mode.cl) && upper_zero;
  assign mrs_accept = mrs_target && fields_ok;
  assign mrs_reject = mrs_target && !fields_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= MODE_RESET;
      mode_err <= 1'b0;
    end else begin
      if (mrs_accept) mode <= req_mode;
      if (mrs_reject) mode_err <= 1'b1;
    end
  end

  AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_accept |=> (mode.bl == $past(mrs_addr[2:0])) && (mode.cl == $past(mrs_addr[6:4]))); // R2
  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_reject |=> $stable(mode) && mode_err); // R3
  AST_BANK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs_valid && mrs_bank != 2'b00) |=> $stable(mode) && $stable(mode_err)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |=> mode_err); // R11

endmodule

// File: rtl/bcs_burst_ctrl.sv
module bcs_burst_ctrl
  import burst_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  mode_t            mode,
  output logic             active,
  output logic [OFS_W-1:0] idx,
  output logic [2:0]       cap_bl,
  output logic             cap_ilv,
  output logic             beat_is_last
);

  logic [4:0] cap_beats;
  logic       burst_end;

  assign cap_beats    = beats_of(cap_bl);
  assign beat_is_last = active && ({1'b0, idx} == cap_beats - 5'd1);
  assign burst_end    = beat_is_last && !cmd_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      idx     <= '0;
      cap_bl  <= MODE_RESET.bl;
      cap_ilv <= MODE_RESET.ileave;
    end else if (cmd_valid) begin
      active  <= 1'b1;
      idx     <= '0;
      cap_bl  <= mode.bl;
      cap_ilv <= mode.ileave;
    end else if (active) begin
      if (burst_end) active <= 1'b0;
      else           idx    <= idx + 1'b1;
    end
  end

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ({1'b0, idx} < cap_beats)); // R5
  AST_CMD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> active && (idx == '0)); // R9
  AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |=> !active); // R8
  AST_CAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cmd_valid) |=> $stable(cap_bl) && $stable(cap_ilv)); // R10

endmodule

// File: rtl/bcs_col_gen.sv
module bcs_col_gen
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             active,
  input  logic             beat_is_last,
  input  logic [OFS_W-1:0] idx,
  input  logic [2:0]       cap_bl,
  input  logic             cap_ilv,
  output logic [COL_W-1:0] beat_col
);

  localparam int HI_W = COL_W - OFS_W;

  logic [COL_W-1:0] col_hold;
  logic [OFS_W-1:0] mask;
  logic [OFS_W-1:0] start_ofs;
  logic [OFS_W-1:0] cur_ofs;
  logic [OFS_W-1:0] low_keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         col_hold <= '0;
    else if (cmd_valid) col_hold <= cmd_col;
  end

  assign mask      = ofs_mask(cap_bl);
  assign start_ofs = col_hold[OFS_W-1:0] & mask;
  assign cur_ofs   = beat_offset(start_ofs, idx, mask, cap_ilv);
  assign low_keep  = col_hold[OFS_W-1:0] & ~mask;
  assign beat_col  = {col_hold[COL_W-1:OFS_W], low_keep | cur_ofs};

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cmd_valid && !beat_is_last) |=> beat_col[COL_W-1:OFS_W] == $past(beat_col[COL_W-1:OFS_W])); // R6
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cap_ilv && !cmd_valid && !beat_is_last) |=>
      ((beat_col[OFS_W-1:0] & mask) == (($past(beat_col[OFS_W-1:0]) + 1'b1) & mask))); // R6
  AST_ILV_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cap_ilv && idx == '0) |-> ((beat_col[OFS_W-1:0] & mask) == start_ofs)); // R7

  logic unused_hi;
  assign unused_hi = (HI_W < 1);

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int COL_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrs_valid,
  input  logic [1:0]        mrs_bank,
  input  logic [ADDR_W-1:0] mrs_addr,
  input  logic              cmd_valid,
  input  logic [COL_W-1:0]  cmd_col,
  output logic              beat_valid,
  output logic [COL_W-1:0]  beat_col,
  output logic              beat_last,
  output logic [4:0]        cfg_beats,
  output logic              cfg_interleave,
  output logic [1:0]        cfg_cas_lat,
  output logic              mode_err
);

  mode_t            mode;
  logic             active;
  logic [OFS_W-1:0] idx;
  logic [2:0]       cap_bl;
  logic             cap_ilv;
  logic             beat_is_last;

  bcs_mode_reg #(.ADDR_W(ADDR_W)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .mrs_valid (mrs_valid),
    .mrs_bank  (mrs_bank),
    .mrs_addr  (mrs_addr),
    .mode      (mode),
    .mode_err  (mode_err)
  );

  bcs_burst_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .mode         (mode),
    .active       (active),
    .idx          (idx),
    .cap_bl       (cap_bl),
    .cap_ilv      (cap_ilv),
    .beat_is_last (beat_is_last)
  );

  bcs_col_gen #(.COL_W(COL_W)) u_col (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_col      (cmd_col),
    .active       (active),
    .beat_is_last (beat_is_last),
    .idx          (idx),
    .cap_bl       (cap_bl),
    .cap_ilv      (cap_ilv),
    .beat_col     (beat_col)
  );

  assign beat_valid     = active;
  assign beat_last      = beat_is_last;
  assign cfg_beats      = beats_of(mode.bl);
  assign cfg_interleave = mode.ileave;
  assign cfg_cas_lat    = mode.cl[1:0];

  AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid); // R8
  AST_CFG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cfg_beats) && (cfg_beats >= 5'd2) && (cfg_cas_lat >= 2'd2)); // R2

  logic unused_cl;
  assign unused_cl = mode.cl[2];

endmodule

// File: tb/sim_burst_col_seq.sv
`timescale 1ns/1ps
module sim_burst_col_seq;

  localparam int ADDR_W = 13;
  localparam int COL_W  = 9;
  localparam int NV     = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              mrs_valid = 1'b0;
  logic [1:0]        mrs_bank = 2'b00;
  logic [ADDR_W-1:0] mrs_addr = '0;
  logic              cmd_valid = 1'b0;
  logic [COL_W-1:0]  cmd_col = '0;
  logic              beat_valid;
  logic [COL_W-1:0]  beat_col;
  logic              beat_last;
  logic [4:0]        cfg_beats;
  logic              cfg_interleave;
  logic [1:0]        cfg_cas_lat;
  logic              mode_err;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  burst_col_seq #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u0 (
    .clk(clk), .rst_n(rst_n), .mrs_valid(mrs_valid), .mrs_bank(mrs_bank),
    .mrs_addr(mrs_addr), .cmd_valid(cmd_valid), .cmd_col(cmd_col),
    .beat_valid(beat_valid), .beat_col(beat_col), .beat_last(beat_last),
    .cfg_beats(cfg_beats), .cfg_interleave(cfg_interleave),
    .cfg_cas_lat(cfg_cas_lat), .mode_err(mode_err)
  );

  // vector table: mode word, start column, beats, order, latency, final column
  localparam logic [12:0] V_MR   [NV] = '{13'h031, 13'h032, 13'h033, 13'h034,
                                         13'h03A, 13'h03B, 13'h03C, 13'h02B};
  localparam logic [8:0]  V_COL  [NV] = '{9'h0A5, 9'h0A6, 9'h1F5, 9'h13B,
                                         9'h0A6, 9'h1F5, 9'h13B, 9'h000};
  localparam int          V_BEAT [NV] = '{2, 4, 8, 16, 4, 8, 16, 8};
  localparam logic        V_ILV  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam int          V_CL   [NV] = '{3, 3, 3, 3, 3, 3, 3, 2};
  localparam logic [8:0]  V_LAST [NV] = '{9'h0A4, 9'h0A5, 9'h1F4, 9'h13A,
                                         9'h0A5, 9'h1F2, 9'h134, 9'h007};

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // block base plus the walked position, computed by stepping rather than arithmetic
  function automatic int model_col(input int start, input int i, input int beats, input bit ilv);
    int pos = start % beats;
    int base = start - pos;
    if (ilv) begin
      pos = (pos & ~i) | (~pos & i);
      pos = pos % beats;
    end else begin
      for (int k = 0; k < i; k++) pos = (pos == beats - 1) ? 0 : pos + 1;
    end
    return base + pos;
  endfunction

  task automatic do_mrs(input logic [1:0] bank, input logic [12:0] val);
    @(negedge clk);
    mrs_valid = 1'b1; mrs_bank = bank; mrs_addr = val;
    @(negedge clk);
    mrs_valid = 1'b0; mrs_bank = 2'b00; mrs_addr = '0;
  endtask

  task automatic run_burst(input int col, input int beats, input bit ilv, input string req);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_col = col[COL_W-1:0];
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < beats; i++) begin
      chk({req, " R5 valid"}, beat_valid, 1);
      chk({req, " column"}, beat_col, model_col(col, i, beats, ilv));
      chk({req, " R8 last"}, beat_last, (i == beats - 1));
      if (i < beats - 1) @(negedge clk);
    end
    @(negedge clk);
    chk({req, " R5 valid drops"}, beat_valid, 0);
    chk({req, " R8 last low"}, beat_last, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 beats", cfg_beats, 2);
    chk("R1 order", cfg_interleave, 0);
    chk("R1 cas", cfg_cas_lat, 3);
    chk("R1 err", mode_err, 0);
    chk("R1 valid", beat_valid, 0);

    // R4 nonzero bank selector ignored
    do_mrs(2'b01, 13'h03B);
    chk("R4 bank beats", cfg_beats, 2);
    chk("R4 bank order", cfg_interleave, 0);
    chk("R4 bank err", mode_err, 0);

    // table walk: R2 decode, R6 sequential, R7 interleaved
    for (int v = 0; v < NV; v++) begin
      do_mrs(2'b00, V_MR[v]);
      chk("R2 beats", cfg_beats, V_BEAT[v]);
      chk("R2 order", cfg_interleave, V_ILV[v]);
      chk("R2 cas", cfg_cas_lat, V_CL[v]);
      chk("R2 err", mode_err, 0);
      run_burst(V_COL[v], V_BEAT[v], V_ILV[v], V_ILV[v] ? "R7" : "R6");
      chk(V_ILV[v] ? "R7 final column" : "R6 final column", model_col(V_COL[v], V_BEAT[v] - 1, V_BEAT[v], V_ILV[v]), V_LAST[v]);
    end

    // R9 restart in mid-burst: 8-beat sequential
    do_mrs(2'b00, 13'h033);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_col = 9'h010;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    chk("R9 old beat1", beat_col, 9'h011);
    cmd_valid = 1'b1; cmd_col = 9'h025;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R9 new beat0", beat_col, 9'h025);
    chk("R9 not last", beat_last, 0);
    for (int i = 1; i < 8; i++) begin
      @(negedge clk);
      chk("R9 new column", beat_col, model_col(9'h025, i, 8, 1'b0));
    end
    chk("R9 last", beat_last, 1);
    @(negedge clk);
    chk("R9 ends", beat_valid, 0);

    // R10 mode write during a burst
    @(negedge clk);
    cmd_valid = 1'b1; cmd_col = 9'h046;
    @(negedge clk);
    cmd_valid = 1'b0;
    mrs_valid = 1'b1; mrs_addr = 13'h039;
    @(negedge clk);
    mrs_valid = 1'b0; mrs_addr = '0;
    chk("R10 new cfg", cfg_beats, 2);
    for (int i = 1; i < 8; i++) begin
      chk("R10 valid", beat_valid, 1);
      chk("R10 column", beat_col, model_col(9'h046, i, 8, 1'b0));
      if (i < 7) @(negedge clk);
    end
    chk("R10 last", beat_last, 1);

    // R4 upper bit set with bank 0
    do_reset();
    do_mrs(2'b00, 13'h0B3);
    chk("R4 upper err", mode_err, 1);
    chk("R4 upper beats", cfg_beats, 2);

    // R3 reserved codes
    do_reset();
    do_mrs(2'b00, 13'h030);
    chk("R3 bl err", mode_err, 1);
    chk("R3 bl kept", cfg_beats, 2);
    do_mrs(2'b00, 13'h03D);
    chk("R3 bl 101 kept", cfg_beats, 2);
    chk("R3 order kept", cfg_interleave, 0);
    do_reset();
    do_mrs(2'b00, 13'h012);
    chk("R3 cl err", mode_err, 1);
    chk("R3 cl kept", cfg_cas_lat, 3);
    chk("R3 cl beats kept", cfg_beats, 2);

    // R11 sticky flag
    do_mrs(2'b00, 13'h023);
    chk("R11 cfg loads", cfg_beats, 8);
    chk("R11 cas loads", cfg_cas_lat, 2);
    chk("R11 err sticky", mode_err, 1);
    do_reset();
    chk("R11 reset clears", mode_err, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule